// File: doc/BRIEF.md
# Sensor Programming Frame Parser

This block sits on the sensor side of a single-wire programming link. A line decoder delivers one recovered bit at a time, plus strobes that mark the beginning and the end of each host frame. The parser collects the bits and validates the header parity, the frame length and, for write-type frames, the 4-bit checksum. It then carries out one of three commands against a register port with an 8-bit address. It also keeps a 2-bit bank register that is placed above the 5-bit offset carried in every frame.

Every accepted command produces one response request for the transmit path. A read returns the register word together with a checksum computed over that word alone. A write or a bank change returns a first acknowledge. A write that the register side marks as starting a programming cycle also arms a second acknowledge, which is sent once the programming cycle reports success. A frame that fails any check gets no response and causes no register access. While a lock input is set, the parser answers nothing.

Top module: `prog_frame_parser`

## Requirements
- R1: A frame is judged on the cycle `frm_end` is high, using the bits received since the last `frm_start` or `frm_end`. A read is valid only with exactly 11 bits and a write-type frame only with exactly 31. The first bit (sync) must be 0. A command whose length does not match, or any other length, gives no access and no response.
- R2: Bits are sent most significant first. The header is sync, a 3-bit command, a 5-bit offset and a parity bit. The parity bit must be 1 when the command and offset bits hold an even count of ones, and 0 otherwise. A mismatch drops the frame.
- R3: A write-type frame continues with a filler bit that must be 0, then 16 data bits, then a 4-bit checksum. The checksum uses polynomial x^4+x+1, starts from 0, and is taken MSB first over command, offset, parity, filler and data (26 bits). A mismatch or a filler of 1 drops the frame.
- R4: The command codes are 1 (read, whose 11th bit may take any value), 3 (set bank) and 6 (write). Any other code is dropped.
- R5: A valid read drives `reg_rd` with `reg_addr = {0, bank, offset}` in the `frm_end` cycle. On the next cycle `rsp_valid` is high with `rsp_kind` = 1, `rsp_data` set to the word read, and `rsp_crc` set to the checksum over those 16 data bits alone.
- R6: A valid write drives `reg_wr`, `reg_addr` and `reg_wdata` in the `frm_end` cycle. On the next cycle it responds with `rsp_kind` = 2 (first acknowledge).
- R7: Set bank (code 3) requires offset 0 and data bits 15..2 equal to 0. It then loads `base_o` from data bits 1..0 by the next cycle, responds with kind 2, and makes no register write.
- R8: When `reg_deny` is high for the computed address, a read or a write makes no access and gets no response.
- R9: A write accepted while `reg_prog` is high arms a second acknowledge. If `prog_done` is then pulsed with `prog_ok` high, `rsp_kind` = 3 is sent two cycles after the pulse. If `prog_ok` is low, nothing is sent.
- R10: While `prog_busy` is high, or while a second acknowledge is armed or waiting to be sent, write and set-bank frames are dropped: no access, no bank change, no response. Reads are still answered.
- R11: While `lock_i` is high, no frame causes an access, a bank change or a response.
- R12: A `frm_start` pulse throws away any bits collected so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | A decoded bit is present this cycle |
| bit_val | input | 1 | Value of the decoded bit |
| frm_start | input | 1 | New frame begins; clears collected bits |
| frm_end | input | 1 | Line went idle; judge the collected frame |
| lock_i | input | 1 | Lock active; answer nothing |
| prog_busy | input | 1 | Non-volatile programming in progress |
| prog_done | input | 1 | Programming cycle finished (pulse) |
| prog_ok | input | 1 | Result of the finished programming cycle |
| reg_addr | output | 8 | Effective register address |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, combinational on reg_addr |
| reg_deny | input | 1 | Address forbidden, combinational on reg_addr |
| reg_prog | input | 1 | A write here starts programming, combinational |
| base_o | output | 2 | Current bank |
| rsp_valid | output | 1 | Response request, one cycle |
| rsp_kind | output | 2 | 1 read data, 2 first ack, 3 second ack |
| rsp_data | output | 16 | Read data to transmit |
| rsp_crc | output | 4 | Checksum of read data |

## Verification
The bench uses the default `ADDR_W` of 8, so the bank and offset fill seven address bits and the top bit stays zero. Its register model forbids address 0x25 (bank 1, offset 5) and marks every bank-0 address as starting a programming cycle. Random bank changes therefore bring denied reads and writes within reach, and bank-0 writes lead to the armed second acknowledge, both with and without programming success.

// File: rtl/fp_pkg.sv
package fp_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int CMD_W  = 3;
  localparam int OFF_W  = 5;
  localparam int BASE_W = 2;
  localparam int DATA_W = 16;
  localparam int CRC_W  = 4;
  localparam int HDR_W  = 1 + CMD_W + OFF_W + 1;
  localparam int RD_LEN = HDR_W + 1;
  localparam int WR_LEN = HDR_W + 1 + DATA_W + CRC_W;
  localparam int COV_W  = WR_LEN - 1 - CRC_W;
  localparam int PAR_W  = CMD_W + OFF_W;
  localparam int CNT_W  = $clog2(WR_LEN + 2);

  localparam logic [CMD_W-1:0] CMD_RD = 3'd1;
  localparam logic [CMD_W-1:0] CMD_SB = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WR = 3'd6;
  localparam logic [CRC_W-1:0] CRC_TAPS = 4'b0011;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_DATA = 2'd1,
    RSP_ACK1 = 2'd2,
    RSP_ACK2 = 2'd3
  } rsp_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc_cover(input logic [COV_W-1:0] v);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = COV_W - 1; i >= 0; i--) c = crc_step(c, v[i]);
    return c;
  endfunction

  function automatic logic [CRC_W-1:0] crc_word(input logic [DATA_W-1:0] v);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = DATA_W - 1; i >= 0; i--) c = crc_step(c, v[i]);
    return c;
  endfunction

  function automatic logic odd_fill(input logic [PAR_W-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/fp_assembler.sv
module fp_assembler
  import fp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic [WR_LEN-1:0] sr,
  output logic [CNT_W-1:0]  cnt
);
  timeunit 1ns; timeprecision 1ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clr) begin
      sr  <= '0;
      cnt <= '0;
    end else if (bit_vld) begin
      sr <= {sr[WR_LEN-2:0], bit_val};
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fp_decode.sv
module fp_decode
  import fp_pkg::*;
(
  input  logic [WR_LEN-1:0] sr,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CMD_W-1:0]  cmd,
  output logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] data,
  output logic              rd_ok,
  output logic              wr_fmt_ok
);
  timeunit 1ns; timeprecision 1ps;

  logic              len_rd, len_wr, sync_ok, par_ok, fill_ok, crc_ok;
  logic [HDR_W-1:0]  hdr;

  assign len_rd  = (cnt == CNT_W'(RD_LEN));
  assign len_wr  = (cnt == CNT_W'(WR_LEN));
  assign hdr     = len_rd ? sr[RD_LEN-1:1] : sr[WR_LEN-1 -: HDR_W];
  assign cmd     = hdr[HDR_W-2 -: CMD_W];
  assign off     = hdr[1 +: OFF_W];
  assign data    = sr[CRC_W +: DATA_W];
  assign sync_ok = ~hdr[HDR_W-1];
  assign par_ok  = (hdr[0] == odd_fill({cmd, off}));
  assign fill_ok = ~sr[CRC_W + DATA_W];
  assign crc_ok  = (sr[CRC_W-1:0] == crc_cover(sr[WR_LEN-2:CRC_W]));

  assign rd_ok     = len_rd & sync_ok & par_ok & (cmd == CMD_RD);
  assign wr_fmt_ok = len_wr & sync_ok & par_ok & fill_ok & crc_ok &
                     ((cmd == CMD_WR) | (cmd == CMD_SB));
endmodule

// File: rtl/fp_respond.sv
module fp_respond
  import fp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              ack1_go,
  input  logic              arm,
  input  logic              prog_done,
  input  logic              prog_ok,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] rdata,
  output logic              armed,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CRC_W-1:0]  rsp_crc
);
  timeunit 1ns; timeprecision 1ps;

  logic pend, due;
  rsp_e kind_q;

  assign armed    = pend | due;
  assign rsp_kind = kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      due       <= 1'b0;
      rsp_valid <= 1'b0;
      kind_q    <= RSP_NONE;
      rsp_data  <= '0;
      rsp_crc   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (arm) begin
        pend <= 1'b1;
      end else if (prog_done && pend) begin
        pend <= 1'b0;
        due  <= prog_ok;
      end
      if (rd_go) begin
        rsp_valid <= 1'b1;
        kind_q    <= RSP_DATA;
        rsp_data  <= rdata;
        rsp_crc   <= crc_word(rdata);
      end else if (ack1_go) begin
        rsp_valid <= 1'b1;
        kind_q    <= RSP_ACK1;
        rsp_data  <= '0;
        rsp_crc   <= '0;
      end else if (due && !lock_i) begin
        rsp_valid <= 1'b1;
        kind_q    <= RSP_ACK2;
        rsp_data  <= '0;
        rsp_crc   <= '0;
        due       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prog_frame_parser.sv
module prog_frame_parser
  import fp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              lock_i,
  input  logic              prog_busy,
  input  logic              prog_done,
  input  logic              prog_ok,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [15:0]       reg_wdata,
  input  logic [15:0]       reg_rdata,
  input  logic              reg_deny,
  input  logic              reg_prog,
  output logic [1:0]        base_o,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [15:0]       rsp_data,
  output logic [3:0]        rsp_crc
);
  timeunit 1ns; timeprecision 1ps;

  localparam int EFF_W = BASE_W + OFF_W;
  localparam int PAD_W = ADDR_W - EFF_W;

  logic [WR_LEN-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  f_cmd;
  logic [OFF_W-1:0]  f_off;
  logic [DATA_W-1:0] f_data;
  logic              rd_ok, wr_fmt_ok;
  logic              eval, wr_block, rd_go, wr_go, sb_go, sb_fields_ok, armed;
  logic [BASE_W-1:0] base_q;

  fp_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .clr(frm_start | frm_end),
    .bit_vld(bit_vld), .bit_val(bit_val), .sr(sr), .cnt(cnt)
  );

  fp_decode u_dec (
    .sr(sr), .cnt(cnt), .cmd(f_cmd), .off(f_off), .data(f_data),
    .rd_ok(rd_ok), .wr_fmt_ok(wr_fmt_ok)
  );

  assign eval         = frm_end & ~lock_i;
  assign wr_block     = prog_busy | armed;
  assign sb_fields_ok = (f_off == '0) && (f_data[DATA_W-1:BASE_W] == '0);
  assign rd_go        = eval & rd_ok & ~reg_deny;
  assign wr_go        = eval & wr_fmt_ok & (f_cmd == CMD_WR) & ~reg_deny & ~wr_block;
  assign sb_go        = eval & wr_fmt_ok & (f_cmd == CMD_SB) & sb_fields_ok & ~wr_block;

  assign reg_addr  = {{PAD_W{1'b0}}, base_q, f_off};
  assign reg_rd    = rd_go;
  assign reg_wr    = wr_go;
  assign reg_wdata = f_data;
  assign base_o    = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (sb_go) base_q <= f_data[BASE_W-1:0];
  end

  fp_respond u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .ack1_go(wr_go | sb_go),
    .arm(wr_go & reg_prog), .prog_done(prog_done), .prog_ok(prog_ok),
    .lock_i(lock_i), .rdata(reg_rdata), .armed(armed),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data), .rsp_crc(rsp_crc)
  );
endmodule

// File: rtl/fp_checker.sv
module fp_checker
  import fp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        frm_end,
  input logic        lock_i,
  input logic        prog_busy,
  input logic        prog_done,
  input logic        prog_ok,
  input logic        reg_rd,
  input logic        reg_wr,
  input logic [15:0] reg_rdata,
  input logic [1:0]  base_o,
  input logic        rsp_valid,
  input logic [1:0]  rsp_kind,
  input logic [15:0] rsp_data,
  input logic        wr_block
);
  timeunit 1ns; timeprecision 1ps;

  logic ok_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_seen <= 1'b0;
    else if (prog_done && prog_ok) ok_seen <= 1'b1;
    else if (rsp_valid && rsp_kind == RSP_ACK2) ok_seen <= 1'b0;
  end

  AST_RSP_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(lock_i)); // R11
  AST_ACCESS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) |-> (frm_end && !lock_i)); // R1
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr)); // R4
  AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !prog_busy); // R10
  AST_READ_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RSP_DATA) |-> ($past(reg_rd) && rsp_data == $past(reg_rdata))); // R5
  AST_ACK1_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RSP_ACK1) |-> $past(frm_end)); // R6
  AST_BANK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_o) |-> $past(frm_end && !lock_i && !wr_block)); // R7
  AST_ACK2_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RSP_ACK2) |-> ok_seen); // R9
endmodule

bind prog_frame_parser fp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .lock_i(lock_i),
  .prog_busy(prog_busy), .prog_done(prog_done), .prog_ok(prog_ok),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata), .base_o(base_o),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
  .wr_block(wr_block)
);

// File: tb/prog_frame_parser_test.sv
module prog_frame_parser_test;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [7:0] DENY_A = 8'h25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 0, bit_val = 0, frm_start = 0, frm_end = 0;
  logic lock_i = 0, prog_busy = 0, prog_done = 0, prog_ok = 0;
  logic [7:0]  reg_addr;
  logic        reg_rd, reg_wr, reg_deny, reg_prog, rsp_valid;
  logic [15:0] reg_wdata, reg_rdata, rsp_data;
  logic [1:0]  base_o, rsp_kind;
  logic [3:0]  rsp_crc;
  logic [15:0] mem [0:127];

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic        c_rd, c_wr, c_rv;
  logic [7:0]  c_addr;
  logic [15:0] c_wdata, c_rdat;
  logic [1:0]  c_rk;
  logic [3:0]  c_rcrc;
  logic [1:0]  eb = 2'd0;

  always #2.5 clk = ~clk;

  assign reg_rdata = mem[reg_addr[6:0]];
  assign reg_deny  = (reg_addr == DENY_A);
  assign reg_prog  = (reg_addr[6:5] == 2'd0);
  always @(posedge clk) if (reg_wr) mem[reg_addr[6:0]] <= reg_wdata;

  prog_frame_parser uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .frm_start(frm_start), .frm_end(frm_end), .lock_i(lock_i),
    .prog_busy(prog_busy), .prog_done(prog_done), .prog_ok(prog_ok),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_deny(reg_deny), .reg_prog(reg_prog),
    .base_o(base_o), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data), .rsp_crc(rsp_crc)
  );

  function automatic logic [3:0] bcrc(input logic [31:0] v, input int n);
    logic [4:0] r = '0;
    for (int i = n - 1; i >= -4; i--) begin
      r = {r[3:0], (i >= 0) ? v[i] : 1'b0};
      if (r[4]) r = r ^ 5'b10011;
    end
    return r[3:0];
  endfunction

  function automatic logic bpar(input logic [7:0] v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    return (ones % 2 == 0);
  endfunction

  function automatic logic [31:0] wfr(input logic [2:0] c, input logic [4:0] a,
                                      input logic [15:0] d, input bit fp, input bit fc, input bit dm);
    logic p; logic [25:0] cov; logic [3:0] k;
    p = bpar({c, a}) ^ fp;
    cov = {c, a, p, dm, d};
    k = bcrc(32'(cov), 26) ^ {3'b0, fc};
    return {2'b00, c, a, p, dm, d, k};
  endfunction

  function automatic logic [31:0] rfr(input logic [2:0] c, input logic [4:0] a, input bit fp, input bit tr);
    return 32'({1'b0, c, a, bpar({c, a}) ^ fp, tr});
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] v, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); bit_vld = 1'b1; bit_val = v[i];
    end
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] v, input int len);
    send(v, len);
    frm_end = 1'b1; #1;
    c_rd = reg_rd; c_wr = reg_wr; c_addr = reg_addr; c_wdata = reg_wdata;
    @(negedge clk); frm_end = 1'b0;
    c_rv = rsp_valid; c_rk = rsp_kind; c_rdat = rsp_data; c_rcrc = rsp_crc;
  endtask

  task automatic exp_rsp(input string req, input bit v, input logic [1:0] k, input logic [15:0] d);
    chk(req, "rsp_valid", 32'(c_rv), 32'(v));
    if (v) begin
      chk(req, "rsp_kind", 32'(c_rk), 32'(k));
      if (k == 2'd1) begin
        chk(req, "rsp_data", 32'(c_rdat), 32'(d));
        chk(req, "rsp_crc", 32'(c_rcrc), 32'(bcrc(32'(d), 16)));
      end
    end
  endtask

  task automatic pulse_done(input bit ok, input string req);
    @(negedge clk); prog_done = 1'b1; prog_ok = ok;
    @(negedge clk); prog_done = 1'b0; prog_ok = 1'b0;
    chk(req, "no early ack2", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk(req, "ack2 valid", 32'(rsp_valid), 32'(ok));
    if (ok) chk(req, "ack2 kind", 32'(rsp_kind), 32'd3);
  endtask

  task automatic set_bank(input logic [1:0] b, input string req);
    run_frame(wfr(3'd3, 5'd0, {14'd0, b}, 0, 0, 0), 31);
    exp_rsp(req, 1, 2'd2, 16'd0);
    eb = b;
    chk(req, "bank", 32'(base_o), 32'(b));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, ev;
    logic [4:0]  a;
    logic [2:0]  c;
    logic [7:0]  ea;
    for (int i = 0; i < 128; i++) mem[i] = 16'(i * 16'h0123 + 16'h5A);
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "reset rsp_valid", 32'(rsp_valid), 0);
    chk("R7", "reset bank", 32'(base_o), 0);
    chk("R6", "reset reg_wr", 32'(reg_wr), 0);

    // R7 R3: literal set-bank frame, bank 1, checksum 0xD
    run_frame({2'b00, 3'd3, 5'd0, 1'b1, 1'b0, 16'h0001, 4'hD}, 31);
    exp_rsp("R7", 1, 2'd2, 0);
    chk("R7", "bank literal", 32'(base_o), 1);
    chk("R7", "no reg_wr", 32'(c_wr), 0);
    eb = 2'd1;
    // R8: denied read at bank 1 offset 5
    run_frame(rfr(3'd1, 5'd5, 0, 0), 11);
    chk("R8", "no read", 32'(c_rd), 0);
    exp_rsp("R8", 0, 0, 0);
    run_frame(wfr(3'd6, 5'd5, 16'hBEEF, 0, 0, 0), 31);
    chk("R8", "no write", 32'(c_wr), 0);
    exp_rsp("R8", 0, 0, 0);
    // R7: set bank with nonzero upper data is dropped
    run_frame(wfr(3'd3, 5'd0, 16'h0006, 0, 0, 0), 31);
    exp_rsp("R7", 0, 0, 0);
    chk("R7", "bank kept", 32'(base_o), 1);
    set_bank(2'd0, "R7");

    // R9 R10: armed write blocks writes, reads still answered
    run_frame(wfr(3'd6, 5'd3, 16'h1234, 0, 0, 0), 31);
    chk("R6", "write strobe", 32'(c_wr), 1);
    chk("R6", "write addr", 32'(c_addr), 3);
    exp_rsp("R6", 1, 2'd2, 0);
    run_frame(wfr(3'd6, 5'd4, 16'h7777, 0, 0, 0), 31);
    chk("R10", "write while armed", 32'(c_wr), 0);
    exp_rsp("R10", 0, 0, 0);
    run_frame(rfr(3'd1, 5'd3, 0, 1), 11);
    exp_rsp("R10", 1, 2'd1, 16'h1234);
    pulse_done(1, "R9");
    run_frame(wfr(3'd6, 5'd4, 16'h4321, 0, 0, 0), 31);
    exp_rsp("R9", 1, 2'd2, 0);
    pulse_done(0, "R9");

    // R10: prog_busy drops write and set bank
    prog_busy = 1'b1;
    run_frame(wfr(3'd6, 5'd9, 16'h0F0F, 0, 0, 0), 31);
    chk("R10", "busy write", 32'(c_wr), 0);
    exp_rsp("R10", 0, 0, 0);
    run_frame(wfr(3'd3, 5'd0, 16'h0002, 0, 0, 0), 31);
    exp_rsp("R10", 0, 0, 0);
    chk("R10", "busy bank", 32'(base_o), 0);
    prog_busy = 1'b0;

    // R11: lock silences everything
    lock_i = 1'b1;
    run_frame(rfr(3'd1, 5'd2, 0, 0), 11);
    chk("R11", "locked read", 32'(c_rd), 0);
    exp_rsp("R11", 0, 0, 0);
    run_frame(wfr(3'd3, 5'd0, 16'h0003, 0, 0, 0), 31);
    exp_rsp("R11", 0, 0, 0);
    chk("R11", "locked bank", 32'(base_o), 0);
    lock_i = 1'b0;

    // R12: junk then restart
    send(32'h1F, 5);
    @(negedge clk); frm_start = 1'b1;
    @(negedge clk); frm_start = 1'b0;
    run_frame(rfr(3'd1, 5'd7, 0, 0), 11);
    exp_rsp("R12", 1, 2'd1, mem[7]);
    // R1: one extra bit, and read code in a long frame
    run_frame({rfr(3'd1, 5'd7, 0, 0)[10:0], 1'b0}, 12);
    exp_rsp("R1", 0, 0, 0);
    run_frame(wfr(3'd1, 5'd7, 16'h0, 0, 0, 0), 31);
    exp_rsp("R1", 0, 0, 0);
    run_frame(rfr(3'd1, 5'd7, 0, 0) | 32'h400, 11);
    exp_rsp("R1", 0, 0, 0);

    for (int it = 0; it < 400; it++) begin
      a = 5'($urandom);
      d = 16'($urandom);
      ea = {1'b0, eb, a};
      case ($urandom % 8)
        0, 1, 2: begin
          bit fp;
          fp = ($urandom % 6 == 0);
          ev = mem[ea[6:0]];
          run_frame(rfr(3'd1, a, fp, 1'($urandom)), 11);
          if (fp || ea == DENY_A) exp_rsp("R2", 0, 0, 0);
          else begin
            chk("R5", "read addr", 32'(c_addr), 32'(ea));
            exp_rsp("R5", 1, 2'd1, ev);
          end
        end
        3, 4: begin
          int cr;
          bit good;
          cr = $urandom % 5;
          good = (cr > 2) && (ea != DENY_A);
          run_frame(wfr(3'd6, a, d, cr == 0, cr == 1, cr == 2), 31);
          chk("R3", "write strobe", 32'(c_wr), 32'(good));
          if (good) begin
            chk("R6", "wdata", 32'(c_wdata), 32'(d));
            chk("R6", "waddr", 32'(c_addr), 32'(ea));
          end
          exp_rsp("R6", good, 2'd2, 0);
          if (good && eb == 2'd0) pulse_done(1'($urandom), "R9");
        end
        5: begin
          logic [1:0] nb;
          bit bad;
          nb = 2'($urandom);
          bad = ($urandom % 4 == 0);
          run_frame(wfr(3'd3, bad ? (a | 5'd1) : 5'd0, {14'd0, nb}, 0, 0, 0), 31);
          if (!bad) eb = nb;
          exp_rsp("R7", !bad, 2'd2, 0);
          chk("R7", "bank", 32'(base_o), 32'(eb));
        end
        6: begin
          case ($urandom % 5)
            0: c = 3'd0; 1: c = 3'd2; 2: c = 3'd4; 3: c = 3'd5; default: c = 3'd7;
          endcase
          if ($urandom % 2 == 0) run_frame(rfr(c, a, 0, 0), 11);
          else run_frame(wfr(c, a, d, 0, 0, 0), 31);
          chk("R4", "no access", 32'(c_rd | c_wr), 0);
          exp_rsp("R4", 0, 0, 0);
        end
        default: begin
          if ($urandom % 2 == 0) run_frame(wfr(3'd1, a, d, 0, 0, 0), 31);
          else run_frame(rfr(3'd6, a, 0, 0), 11);
          exp_rsp("R1", 0, 0, 0);
        end
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule